// File: doc/BRIEF.md
# Floating-Point Quiet Compare Unit

The block compares two IEEE 754 values of one precision and reports the outcome as a four-bit condition word {N, Z, C, V}. The outcome is less-than, equal, greater-than or unordered. The second operand can be replaced by positive zero, so a value can be tested against zero with no second operand. Half, single and double precision are chosen per request by a two-bit format code. Narrower formats use the low bits of the 64-bit operand buses.

NaN operands give an unordered outcome. An invalid-operation indication is raised only when a signalling NaN is present. The reserved format code, and the half-precision code when half precision is strapped off, are reported as undefined. An undefined request raises no exception and does not change the condition word.

Requests enter on a valid/ready stream and results leave on a valid/ready stream through a single output register. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. When `out_valid` is high and `out_ready` is low, the result holds unchanged. In that case no new request is taken. The half-precision enable is a plain strap pin.

Top module: `fcmp_unit`

## Requirements
- R1: An ordered result drives `out_flags` {N,Z,C,V} to 4'b1000 for less-than, 4'b0110 for equal and 4'b0010 for greater-than.
- R2: A NaN is a value with an all-ones exponent and a nonzero fraction. If either operand is a NaN of either sign, the result is unordered and `out_flags` is 4'b0011.
- R3: A NaN whose most significant fraction bit is 0 is signalling. `out_invalid` is 1 exactly when a defined request has at least one signalling NaN operand. Quiet NaNs give an unordered result with `out_invalid` 0.
- R4: When `in_zero` is 1, the second operand is positive zero of the chosen precision and `in_b` has no effect on any output.
- R5: `in_fmt` 2'b00 selects single precision (bits 31:0), 2'b01 double (bits 63:0) and 2'b11 half (bits 15:0). The operand width is 8 << (in_fmt XOR 2'b10). Bits above the selected width are ignored.
- R6: `in_fmt` 2'b10 is undefined, and so is 2'b11 while `half_en` is 0. Such a request returns `out_undef` 1 and `out_invalid` 0, and leaves `out_flags` at its previous value. Defined requests return `out_undef` 0.
- R7: Positive and negative zero compare equal. Subnormal operands are compared by value, without flushing to zero.
- R8: With equal signs, the larger magnitude is greater for positive operands and smaller for negative operands. Infinities of equal sign compare equal and order correctly against finite values.
- R9: A result appears on `out_valid` in the cycle after its request is accepted. After reset `out_valid`, `out_flags`, `out_invalid` and `out_undef` are 0 and `in_ready` is 1.
- R10: While `out_valid` is 1 and `out_ready` is 0, all outputs hold and `in_ready` is 0. Otherwise `in_ready` is 1, so results stream one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_fmt | input | 2 | Precision code |
| in_zero | input | 1 | Compare first operand with positive zero |
| half_en | input | 1 | Half-precision enable strap |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_flags | output | 4 | Condition word {N,Z,C,V} |
| out_invalid | output | 1 | Invalid-operation indication |
| out_undef | output | 1 | Request used an undefined format code |

## Verification
Every result passes through one register, so a fault in the comparison path shows at the ports in the very next result. It appears as a wrong condition word, a stray invalid indication or a missing one. A fault in the held condition word shows only at the first undefined request after it, because that request must echo the previous flags. A fault in the handshake state shows within one cycle of a stall: a result that moves or disappears while `out_ready` is low, or `in_ready` high while a result is blocked. The scoreboard then finds its queue out of step with the outputs.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int NUM_PREC = 3;  // index 0 half, 1 single, 2 double

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'b00,
    FMT_DOUBLE = 2'b01,
    FMT_RSVD   = 2'b10,
    FMT_HALF   = 2'b11
  } fmt_code_e;

  typedef enum logic [1:0] {
    REL_LT,
    REL_EQ,
    REL_GT,
    REL_UN
  } rel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // total width of precision index p
  function automatic int prec_width(input int p);
    return 16 << p;
  endfunction

  // exponent width of precision index p
  function automatic int prec_exp_w(input int p);
    case (p)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  // precision index from a format code: (code ^ 2'b10) - 1, reserved code wraps to 3
  function automatic logic [1:0] code_to_prec(input logic [1:0] code);
    return (code ^ 2'b10) - 2'b01;
  endfunction

  function automatic nzcv_t rel_to_flags(input rel_e r);
    case (r)
      REL_LT:  return '{n: 1'b1, z: 1'b0, c: 1'b0, v: 1'b0};
      REL_EQ:  return '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};
      REL_GT:  return '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b0};
      default: return '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b1};
    endcase
  endfunction

endpackage

// File: rtl/fcmp_operand_unpack.sv
module fcmp_operand_unpack
  import fcmp_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int MAG_W = DATA_W - 1
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [1:0]        prec_idx,
  output logic              sign,
  output logic [MAG_W-1:0]  mag,
  output logic              is_nan,
  output logic              is_snan
);

  logic [NUM_PREC-1:0] sign_v;
  logic [NUM_PREC-1:0] nan_v;
  logic [NUM_PREC-1:0] snan_v;
  logic [MAG_W-1:0]    mag_v [NUM_PREC];

  for (genvar g = 0; g < NUM_PREC; g++) begin : g_prec
    localparam int W  = prec_width(g);
    localparam int EW = prec_exp_w(g);
    localparam int FW = W - 1 - EW;

    logic [EW-1:0] expo;
    logic [FW-1:0] frac;

    assign expo      = raw[W-2 -: EW];
    assign frac      = raw[FW-1:0];
    assign sign_v[g] = raw[W-1];
    assign mag_v[g]  = MAG_W'(raw[W-2:0]);
    assign nan_v[g]  = (&expo) && (|frac);
    assign snan_v[g] = nan_v[g] && !frac[FW-1];
  end

  always_comb begin
    sign    = 1'b0;
    mag     = '0;
    is_nan  = 1'b0;
    is_snan = 1'b0;
    for (int i = 0; i < NUM_PREC; i++) begin
      if (prec_idx == 2'(i)) begin
        sign    = sign_v[i];
        mag     = mag_v[i];
        is_nan  = nan_v[i];
        is_snan = snan_v[i];
      end
    end
  end

endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             sign_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             nan_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             nan_b,
  output rel_e             rel
);

  logic both_zero;
  logic a_larger;

  assign both_zero = (mag_a == '0) && (mag_b == '0);
  assign a_larger  = mag_a > mag_b;

  always_comb begin
    if (nan_a || nan_b) begin
      rel = REL_UN;
    end else if (both_zero) begin
      rel = REL_EQ;
    end else if (sign_a != sign_b) begin
      rel = sign_a ? REL_LT : REL_GT;
    end else if (mag_a == mag_b) begin
      rel = REL_EQ;
    end else begin
      // magnitude order flips for negative operands
      rel = (a_larger ^ sign_a) ? REL_GT : REL_LT;
    end
  end

endmodule

// File: rtl/fcmp_out_stage.sv
module fcmp_out_stage
  import fcmp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  nzcv_t flags_d,
  input  logic  inv_d,
  input  logic  undef_d,
  output logic  out_valid,
  input  logic  out_ready,
  output nzcv_t flags_q,
  output logic  inv_q,
  output logic  undef_q
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flags_q   <= '0;
      inv_q     <= 1'b0;
      undef_q   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      undef_q   <= undef_d;
      inv_q     <= inv_d && !undef_d;
      if (!undef_d) begin
        flags_q <= flags_d;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int MAG_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        in_fmt,
  input  logic              in_zero,
  input  logic              half_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_flags,
  output logic              out_invalid,
  output logic              out_undef
);

  logic [1:0]        prec_idx;
  logic              undef_req;
  logic [DATA_W-1:0] b_eff;
  logic              sign_a, sign_b;
  logic [MAG_W-1:0]  mag_a, mag_b;
  logic              nan_a, nan_b;
  logic              snan_a, snan_b;
  rel_e              rel;
  nzcv_t             flags_d;
  nzcv_t             flags_q;

  assign prec_idx  = code_to_prec(in_fmt);
  assign undef_req = (in_fmt == FMT_RSVD) || ((in_fmt == FMT_HALF) && !half_en);
  // positive zero is all-zero bits in every precision
  assign b_eff     = in_zero ? '0 : in_b;

  fcmp_operand_unpack #(.DATA_W(DATA_W)) u_unpack_a (
    .raw(in_a), .prec_idx(prec_idx),
    .sign(sign_a), .mag(mag_a), .is_nan(nan_a), .is_snan(snan_a)
  );

  fcmp_operand_unpack #(.DATA_W(DATA_W)) u_unpack_b (
    .raw(b_eff), .prec_idx(prec_idx),
    .sign(sign_b), .mag(mag_b), .is_nan(nan_b), .is_snan(snan_b)
  );

  fcmp_relation #(.MAG_W(MAG_W)) u_rel (
    .sign_a(sign_a), .mag_a(mag_a), .nan_a(nan_a),
    .sign_b(sign_b), .mag_b(mag_b), .nan_b(nan_b),
    .rel(rel)
  );

  assign flags_d = rel_to_flags(rel);

  fcmp_out_stage u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .flags_d(flags_d), .inv_d(snan_a || snan_b), .undef_d(undef_req),
    .out_valid(out_valid), .out_ready(out_ready),
    .flags_q(flags_q), .inv_q(out_invalid), .undef_q(out_undef)
  );

  assign out_flags = flags_q;

endmodule

// File: rtl/fcmp_unit_checker.sv
module fcmp_unit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_fmt,
  input logic       half_en,
  input logic       out_valid,
  input logic       out_ready,
  input logic [3:0] out_flags,
  input logic       out_invalid,
  input logic       out_undef
);

  logic undef_in;
  assign undef_in = (in_fmt == 2'b10) || ((in_fmt == 2'b11) && !half_en);

  assert_flags_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_undef |->
      (out_flags == 4'b1000) || (out_flags == 4'b0110) ||
      (out_flags == 4'b0010) || (out_flags == 4'b0011));

  assert_invalid_unordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_flags == 4'b0011);

  assert_undef_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> !out_invalid);

  assert_undef_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && undef_in |=> $stable(out_flags) && out_undef);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      out_valid && $stable(out_flags) && $stable(out_invalid) && $stable(out_undef));

  assert_ready_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_no_ready_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

bind fcmp_unit fcmp_unit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_fmt(in_fmt), .half_en(half_en), .out_valid(out_valid),
  .out_ready(out_ready), .out_flags(out_flags),
  .out_invalid(out_invalid), .out_undef(out_undef)
);

// File: tb/tb_fcmp_unit.sv
`timescale 1ns/1ps
module tb_fcmp_unit;

  localparam logic [3:0] F_LT = 4'b1000;
  localparam logic [3:0] F_EQ = 4'b0110;
  localparam logic [3:0] F_GT = 4'b0010;
  localparam logic [3:0] F_UN = 4'b0011;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_a, in_b;
  logic [1:0]  in_fmt;
  logic        in_zero;
  logic        half_en;
  logic        out_valid;
  logic        out_ready;
  logic [3:0]  out_flags;
  logic        out_invalid;
  logic        out_undef;

  always #10 clk = ~clk;  // 50 MHz

  fcmp_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_fmt(in_fmt), .in_zero(in_zero),
    .half_en(half_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_flags(out_flags), .out_invalid(out_invalid), .out_undef(out_undef)
  );

  typedef struct {
    logic [3:0] f;
    logic       inv;
    logic       und;
    string      req;
  } exp_t;

  exp_t       sb[$];
  exp_t       mon_e;
  int         checks = 0;
  int         fails  = 0;
  logic [3:0] model_flags = 4'b0000;
  bit         done = 1'b0;
  bit         toggling = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] a, input logic [63:0] b,
                      input logic [1:0] fmt, input logic z, input logic h,
                      input logic [3:0] ef, input logic ei, input logic eu,
                      input string req);
    exp_t e;
    @(negedge clk);
    in_a = a; in_b = b; in_fmt = fmt; in_zero = z; half_en = h; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    e.f   = eu ? model_flags : ef;
    e.inv = eu ? 1'b0 : ei;
    e.und = eu;
    e.req = req;
    if (!eu) model_flags = ef;
    sb.push_back(e);
    #1 in_valid = 1'b0;
  endtask

  // monitor: one result per output handshake
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "unexpected result", {58'd0, out_flags, out_invalid, out_undef}, 64'd0);
      end else begin
        mon_e = sb.pop_front();
        check({out_flags, out_invalid, out_undef} == {mon_e.f, mon_e.inv, mon_e.und},
              mon_e.req, "{flags,inv,undef}",
              {58'd0, out_flags, out_invalid, out_undef},
              {58'd0, mon_e.f, mon_e.inv, mon_e.und});
      end
    end
  end

  // back-pressure pattern generator
  initial begin
    forever begin
      @(posedge clk);
      if (toggling) #1 out_ready = ($urandom_range(0, 2) != 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_fmt = 2'b00;
    in_zero = 1'b0; half_en = 1'b1; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0, "R9", "reset out_valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R9", "reset in_ready", 64'(in_ready), 64'd1);
    check({out_flags, out_invalid, out_undef} == 6'd0, "R9", "reset outputs",
          64'({out_flags, out_invalid, out_undef}), 64'd0);

    // R1 single precision ordered
    send(64'h3F800000, 64'h40000000, 2'b00, 0, 1, F_LT, 0, 0, "R1");
    send(64'h40000000, 64'h3F800000, 2'b00, 0, 1, F_GT, 0, 0, "R1");
    send(64'h3F800000, 64'h3F800000, 2'b00, 0, 1, F_EQ, 0, 0, "R1");
    // R8 signs and infinities
    send(64'hBF800000, 64'h3F800000, 2'b00, 0, 1, F_LT, 0, 0, "R8");
    send(64'hBF800000, 64'hC0000000, 2'b00, 0, 1, F_GT, 0, 0, "R8");
    send(64'hC0000000, 64'hBF800000, 2'b00, 0, 1, F_LT, 0, 0, "R8");
    send(64'h7F800000, 64'h7F800000, 2'b00, 0, 1, F_EQ, 0, 0, "R8");
    send(64'hFF800000, 64'hFF800000, 2'b00, 0, 1, F_EQ, 0, 0, "R8");
    send(64'hFF800000, 64'h3F800000, 2'b00, 0, 1, F_LT, 0, 0, "R8");
    send(64'h7F800000, 64'h7F7FFFFF, 2'b00, 0, 1, F_GT, 0, 0, "R8");
    // R7 zeros and subnormals
    send(64'h00000000, 64'h80000000, 2'b00, 0, 1, F_EQ, 0, 0, "R7");
    send(64'h00000001, 64'h00000002, 2'b00, 0, 1, F_LT, 0, 0, "R7");
    send(64'h00000002, 64'h80000001, 2'b00, 0, 1, F_GT, 0, 0, "R7");
    send(64'h80000002, 64'h80000001, 2'b00, 0, 1, F_LT, 0, 0, "R7");
    // R2 quiet NaNs, R3 signalling NaNs
    send(64'h7FC00000, 64'h3F800000, 2'b00, 0, 1, F_UN, 0, 0, "R2");
    send(64'h3F800000, 64'hFFC00000, 2'b00, 0, 1, F_UN, 0, 0, "R2");
    send(64'hFFC00001, 64'hFF800000, 2'b00, 0, 1, F_UN, 0, 0, "R2");
    send(64'h3F800000, 64'h7F800001, 2'b00, 0, 1, F_UN, 1, 0, "R3");
    send(64'hFFBFFFFF, 64'h7FC00000, 2'b00, 0, 1, F_UN, 1, 0, "R3");
    // R5 double and half, upper bits ignored
    send(64'h4000000000000000, 64'h3FF0000000000000, 2'b01, 0, 1, F_GT, 0, 0, "R5");
    send(64'hC000000000000000, 64'h3FF0000000000000, 2'b01, 0, 1, F_LT, 0, 0, "R5");
    send(64'h000000007FC00000, 64'h0000000000000000, 2'b01, 0, 1, F_GT, 0, 0, "R5");
    send(64'h7FF8000000000000, 64'h3FF0000000000000, 2'b01, 0, 1, F_UN, 0, 0, "R3");
    send(64'h7FF0000000000001, 64'h3FF0000000000000, 2'b01, 0, 1, F_UN, 1, 0, "R3");
    send(64'h0000000000003C00, 64'h000000000000C000, 2'b11, 0, 1, F_GT, 0, 0, "R5");
    send(64'hFFFFFFFFFFFF3C00, 64'h0000000000003C00, 2'b11, 0, 1, F_EQ, 0, 0, "R5");
    send(64'hDEADBEEF3F800000, 64'h000000003F800000, 2'b00, 0, 1, F_EQ, 0, 0, "R5");
    send(64'h0000000000007C01, 64'h0000000000003C00, 2'b11, 0, 1, F_UN, 1, 0, "R3");
    send(64'h0000000000007E00, 64'h0000000000003C00, 2'b11, 0, 1, F_UN, 0, 0, "R2");
    // R4 compare with zero, in_b ignored
    send(64'hBF800000, 64'h7F800001, 2'b00, 1, 1, F_LT, 0, 0, "R4");
    send(64'h80000000, 64'h7F800001, 2'b00, 1, 1, F_EQ, 0, 0, "R4");
    send(64'h7F800001, 64'h3F800000, 2'b00, 1, 1, F_UN, 1, 0, "R4");
    send(64'h3FF0000000000000, 64'hFFF0000000000001, 2'b01, 1, 1, F_GT, 0, 0, "R4");
    send(64'h0000000000008001, 64'h0000000000000001, 2'b11, 1, 1, F_LT, 0, 0, "R4");
    // R6 undefined codes keep previous flags
    send(64'h7F800001, 64'h7F800001, 2'b10, 0, 1, F_UN, 1, 1, "R6");
    send(64'h0000000000007C01, 64'h0000000000003C00, 2'b11, 0, 0, F_UN, 1, 1, "R6");
    send(64'h3F800000, 64'h3F800000, 2'b00, 0, 0, F_EQ, 0, 0, "R6");
    send(64'h7F800001, 64'h0, 2'b10, 1, 0, F_GT, 1, 1, "R6");

    // R9 latency and R10 stall behaviour
    while (sb.size() != 0) @(negedge clk);
    @(posedge clk);
    #1 out_ready = 1'b0;
    send(64'h40000000, 64'h3F800000, 2'b00, 0, 1, F_GT, 0, 0, "R10");
    @(negedge clk);
    check(out_valid == 1'b1, "R9", "valid one cycle after accept", 64'(out_valid), 64'd1);
    check(out_flags == F_GT, "R9", "flags one cycle after accept", 64'(out_flags), 64'(F_GT));
    check(in_ready == 1'b0, "R10", "in_ready during stall", 64'(in_ready), 64'd0);
    in_a = 64'h3F800000; in_b = 64'h40000000; in_valid = 1'b1;  // must not be taken
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R10", "valid held", 64'(out_valid), 64'd1);
    check(out_flags == F_GT, "R10", "flags held", 64'(out_flags), 64'(F_GT));
    check(in_ready == 1'b0, "R10", "still stalled", 64'(in_ready), 64'd0);
    in_valid = 1'b0;
    @(posedge clk);
    #1 out_ready = 1'b1;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "drained, no extra result", 64'(out_valid), 64'd0);

    // R10 random back-pressure while streaming
    toggling = 1'b1;
    send(64'h3F800000, 64'h40000000, 2'b00, 0, 1, F_LT, 0, 0, "R10");
    send(64'h7FC00000, 64'h40000000, 2'b00, 0, 1, F_UN, 0, 0, "R10");
    send(64'h4000000000000000, 64'h4000000000000000, 2'b01, 0, 1, F_EQ, 0, 0, "R10");
    send(64'h0, 64'h0, 2'b10, 0, 1, F_LT, 0, 1, "R10");
    send(64'h0000000000004000, 64'h0000000000003C00, 2'b11, 0, 1, F_GT, 0, 0, "R10");
    send(64'h7F800001, 64'h0, 2'b00, 1, 1, F_UN, 1, 0, "R10");
    send(64'hBF800000, 64'hBF800000, 2'b00, 0, 1, F_EQ, 0, 0, "R10");
    toggling = 1'b0;
    @(posedge clk);
    #1 out_ready = 1'b1;
    for (int i = 0; i < 50 && sb.size() != 0; i++) @(negedge clk);
    check(sb.size() == 0, "R10", "all results returned", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule